// File: doc/BRIEF.md
# Binary Tree Hop Router

This block is the routing fabric of a binary tree interconnect. Processing nodes sit at the leaves. Each leaf has a LEVELS-bit address that spells out the path from the root, one bit per level. A leaf adapter takes a packet from its node and stamps the header with the source address. It then computes how far the packet must climb. Let R be the XOR of the source and destination addresses and i the position of the highest set bit of R. The packet climbs i+1 levels to the common ancestor. A per-packet up-hop counter carries that number, and each upward hop takes one off it. Once the counter is spent, the switch at level L steers the packet down by bit L-1 of the destination. The packet thus reaches its leaf after exactly 2(i+1) links. A packet addressed to its own leaf is turned back inside the adapter and never enters the tree.

Every channel is valid/ready. A transfer happens on a rising edge where both are high. A sender must keep valid and data unchanged until the transfer completes. Each switch has one packet register per input. That input's ready is high only while its register is empty. Each output picks among contending inputs round-robin. A packet that loses arbitration stays where it is, so nothing is ever dropped. A stalled output holds its grant, and the data it presents does not change until the transfer completes.

Top module: `ht_tree_fabric`

## Requirements
- R1: A packet injected at leaf A with destination B leaves on eject port B. Its eject word holds, from bit 0 upward: payload (PAY_W bits), destination (LEVELS bits), source (LEVELS bits), hop count (HW bits). The source field equals A and the payload is unchanged. The inject word holds the payload in its low PAY_W bits and the destination above it.
- R2: For A different from B, the hop count equals 2*(i+1), where i is the index of the highest set bit of A XOR B.
- R3: For A equal to B, the packet is ejected at leaf A with a hop count of 0.
- R4: Every accepted packet is ejected exactly once, whatever back-pressure the eject ports apply.
- R5: While ej_valid of a leaf is high and its ej_ready is low, the next cycle still shows ej_valid high and the same ej_data. The same holds on every internal switch output.
- R6: inj_ready is high after reset. In the cycle after a packet is accepted, inj_ready is low.
- R7: The root never drives its upward output. A packet arriving at a leaf from the tree has its up-hop counter at zero.
- R8: When several inputs contend for one output, grants rotate. An input that waits is served before any other input is granted twice. Two leaves that flood the same destination arrive interleaved, never three in a row from one source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | NLEAF | Per-leaf inject valid |
| inj_ready | output | NLEAF | Per-leaf inject ready |
| inj_data | input | NLEAF*(LEVELS+PAY_W) | Per-leaf inject words, leaf 0 in the low slice |
| ej_valid | output | NLEAF | Per-leaf eject valid |
| ej_ready | input | NLEAF | Per-leaf eject ready |
| ej_data | output | NLEAF*(HW+2*LEVELS+PAY_W) | Per-leaf eject words, leaf 0 in the low slice |

## Verification
The bench sends a packet over every source and destination pair. Pairs whose highest differing bit is the top address bit must climb to the root and back. A wrong turnaround level would show up as a hop count off by two per level, or as a packet ejected at the wrong leaf. Packets sent to their own leaf check the loopback path. A design that sent them into the tree would report a nonzero hop count. Random traffic runs against random eject back-pressure. This catches grants that change under a stall, shown as eject data shifting while ready is low. It also catches lost or duplicated packets, which show up as missing or repeated payload identifiers. Two leaves flooding one destination expose an arbiter that starves one input, seen as long runs from a single source.

// File: rtl/ht_pkg.sv
`timescale 1ns/1ps
package ht_pkg;
  typedef enum logic [1:0] {DIR_UP = 2'd0, DIR_LEFT = 2'd1, DIR_RIGHT = 2'd2} dir_e;

  function automatic int msb_index(input logic [31:0] v);
    int r;
    r = -1;
    for (int b = 0; b < 32; b++) if (v[b]) r = b;
    return r;
  endfunction
endpackage

// File: rtl/ht_rr_arb.sv
`timescale 1ns/1ps
module ht_rr_arb #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            adv,
  output logic [NREQ-1:0] gnt
);
  localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int WW = $clog2(NREQ + 1) + 1;

  logic [PW-1:0]   last_q;
  logic            lock_q;
  logic [NREQ-1:0] lock_gnt_q;
  logic [NREQ-1:0] pick;
  logic [PW-1:0]   gidx;

  always_comb begin
    pick = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NREQ;
      if (pick == '0 && req[idx]) pick[idx] = 1'b1;
    end
  end

  assign gnt = lock_q ? lock_gnt_q : pick;

  always_comb begin
    gidx = last_q;
    for (int k = 0; k < NREQ; k++) if (gnt[k]) gidx = PW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q     <= '0;
      lock_q     <= 1'b0;
      lock_gnt_q <= '0;
    end else begin
      lock_q     <= (|gnt) && !adv;
      lock_gnt_q <= gnt;
      if ((|gnt) && adv) last_q <= gidx;
    end
  end

  // R8
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  for (genvar k = 0; k < NREQ; k++) begin : g_wait
    logic [WW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else if (!req[k] || (gnt[k] && adv)) wait_q <= '0;
      else if ((|gnt) && adv) wait_q <= wait_q + 1'b1;
    end
    // R8
    rr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < WW'(NREQ));
  end
endmodule

// File: rtl/ht_leaf.sv
`timescale 1ns/1ps
module ht_leaf
  import ht_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int PAY_W  = 8,
  parameter int ID     = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inj_valid,
  output logic inj_ready,
  input  logic [LEVELS+PAY_W-1:0] inj_data,
  output logic up_valid,
  input  logic up_ready,
  output logic [$clog2(LEVELS+1)+$clog2(2*LEVELS+1)+2*LEVELS+PAY_W-1:0] up_data,
  input  logic dn_valid,
  output logic dn_ready,
  input  logic [$clog2(LEVELS+1)+$clog2(2*LEVELS+1)+2*LEVELS+PAY_W-1:0] dn_data,
  output logic ej_valid,
  input  logic ej_ready,
  output logic [$clog2(2*LEVELS+1)+2*LEVELS+PAY_W-1:0] ej_data
);
  localparam int CW     = $clog2(LEVELS + 1);
  localparam int HW     = $clog2(2 * LEVELS + 1);
  localparam int EW     = HW + 2 * LEVELS + PAY_W;
  localparam int PKW    = CW + EW;
  localparam int DST_LO = PAY_W;
  localparam int SRC_LO = PAY_W + LEVELS;
  localparam int HOP_LO = PAY_W + 2 * LEVELS;
  localparam logic [LEVELS-1:0] MY_ADDR = LEVELS'(ID);

  logic             hold_v;
  logic [PKW-1:0]   hold_d;
  logic [PKW-1:0]   built;
  logic [LEVELS-1:0] dst_in, diff;
  logic [CW-1:0]    cnt_in;
  logic             is_local;
  logic [1:0]       ereq, egnt;
  logic             take_up, take_loc;

  assign dst_in = inj_data[PAY_W +: LEVELS];
  assign diff   = dst_in ^ MY_ADDR;

  always_comb begin
    cnt_in = '0;
    if (diff != '0) cnt_in = CW'(msb_index(32'(diff)) + 1);
    built = {cnt_in, HW'(0), MY_ADDR, dst_in, inj_data[PAY_W-1:0]};
  end

  assign inj_ready = !hold_v;
  assign is_local  = hold_d[DST_LO +: LEVELS] == MY_ADDR;

  always_comb begin
    up_data = hold_d;
    up_data[EW +: CW]     = hold_d[EW +: CW] - 1'b1;
    up_data[HOP_LO +: HW] = hold_d[HOP_LO +: HW] + 1'b1;
  end
  assign up_valid = hold_v && !is_local;

  assign ereq = {hold_v && is_local, dn_valid};

  ht_rr_arb #(.NREQ(2)) u_ej_arb (
    .clk(clk), .rst_n(rst_n), .req(ereq), .adv(ej_ready), .gnt(egnt)
  );

  assign ej_valid = |egnt;
  assign ej_data  = egnt[1] ? hold_d[EW-1:0] : dn_data[EW-1:0];
  assign dn_ready = ej_ready && egnt[0];
  assign take_up  = up_valid && up_ready;
  assign take_loc = egnt[1] && ej_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= 1'b0;
    else if (!hold_v) hold_v <= inj_valid;
    else if (take_up || take_loc) hold_v <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!hold_v && inj_valid) hold_d <= built;
  end

  // R1
  ej_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> ej_data[DST_LO +: LEVELS] == MY_ADDR);
  // R2
  ej_hops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_valid && ej_data[SRC_LO +: LEVELS] != MY_ADDR) |->
      ej_data[HOP_LO +: HW] == HW'(2 * (msb_index(32'(ej_data[SRC_LO +: LEVELS] ^ MY_ADDR)) + 1)));
  // R3
  ej_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_valid && ej_data[SRC_LO +: LEVELS] == MY_ADDR) |-> ej_data[HOP_LO +: HW] == '0);
  // R5
  ej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_valid && !ej_ready) |=> (ej_valid && $stable(ej_data)));
  // R6
  inj_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_ready) |=> !inj_ready);
  // R7
  dn_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_data[EW +: CW] == '0);
endmodule

// File: rtl/ht_switch.sv
`timescale 1ns/1ps
module ht_switch
  import ht_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int PAY_W  = 8,
  parameter int LEVEL  = 1,
  parameter bit ROOT   = 1'b0,
  localparam int PKW   = $clog2(LEVELS+1) + $clog2(2*LEVELS+1) + 2*LEVELS + PAY_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cl_valid,
  output logic           cl_ready,
  input  logic [PKW-1:0] cl_data,
  input  logic           cr_valid,
  output logic           cr_ready,
  input  logic [PKW-1:0] cr_data,
  input  logic           pa_valid,
  output logic           pa_ready,
  input  logic [PKW-1:0] pa_data,
  output logic           up_valid,
  input  logic           up_ready,
  output logic [PKW-1:0] up_data,
  output logic           lf_valid,
  input  logic           lf_ready,
  output logic [PKW-1:0] lf_data,
  output logic           rt_valid,
  input  logic           rt_ready,
  output logic [PKW-1:0] rt_data
);
  localparam int CW     = $clog2(LEVELS + 1);
  localparam int HW     = $clog2(2 * LEVELS + 1);
  localparam int EW     = HW + 2 * LEVELS + PAY_W;
  localparam int HOP_LO = PAY_W + 2 * LEVELS;
  localparam int STEER  = PAY_W + LEVEL - 1;

  logic [2:0]     s_in_v;
  logic [PKW-1:0] s_in_d [3];
  logic [2:0]     sv;
  logic [PKW-1:0] sd [3];
  dir_e           dir [3];
  logic [PKW-1:0] fwd [3];
  logic [2:0]     o_v, o_r;
  logic [PKW-1:0] o_d [3];
  logic [2:0]     take [3];
  logic [2:0]     freed;

  assign s_in_v    = {pa_valid, cr_valid, cl_valid};
  assign s_in_d[0] = cl_data;
  assign s_in_d[1] = cr_data;
  assign s_in_d[2] = pa_data;
  assign cl_ready  = !sv[0];
  assign cr_ready  = !sv[1];
  assign pa_ready  = !sv[2];

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      fwd[s] = sd[s];
      fwd[s][HOP_LO +: HW] = sd[s][HOP_LO +: HW] + 1'b1;
      if (sd[s][EW +: CW] != '0) begin
        dir[s] = DIR_UP;
        fwd[s][EW +: CW] = sd[s][EW +: CW] - 1'b1;
      end else begin
        dir[s] = sd[s][STEER] ? DIR_RIGHT : DIR_LEFT;
      end
    end
  end

  assign o_r = {rt_ready, lf_ready, up_ready};

  for (genvar o = 0; o < 3; o++) begin : g_out
    logic [2:0]     req, gnt;
    logic [PKW-1:0] mux_d;
    always_comb begin
      mux_d = '0;
      for (int s = 0; s < 3; s++) begin
        req[s] = sv[s] && (dir[s] == dir_e'(2'(o)));
        if (gnt[s]) mux_d = fwd[s];
      end
    end
    ht_rr_arb #(.NREQ(3)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .adv(o_r[o]), .gnt(gnt)
    );
    assign o_v[o]  = |gnt;
    assign o_d[o]  = mux_d;
    assign take[o] = gnt & {3{o_r[o]}};
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_v[o] && !o_r[o]) |=> (o_v[o] && $stable(o_d[o])));
  end

  assign freed    = take[0] | take[1] | take[2];
  assign up_valid = o_v[0];
  assign up_data  = o_d[0];
  assign lf_valid = o_v[1];
  assign lf_data  = o_d[1];
  assign rt_valid = o_v[2];
  assign rt_data  = o_d[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sv <= '0;
    else begin
      for (int s = 0; s < 3; s++) begin
        if (!sv[s]) sv[s] <= s_in_v[s];
        else if (freed[s]) sv[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 3; s++) if (!sv[s] && s_in_v[s]) sd[s] <= s_in_d[s];
  end

  if (ROOT) begin : g_root
    // R7
    root_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n) !o_v[0]);
  end
endmodule

// File: rtl/ht_tree_fabric.sv
`timescale 1ns/1ps
module ht_tree_fabric #(
  parameter int LEVELS = 3,
  parameter int PAY_W  = 8,
  localparam int NLEAF = 1 << LEVELS,
  localparam int IW    = LEVELS + PAY_W,
  localparam int EW    = $clog2(2*LEVELS+1) + 2*LEVELS + PAY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLEAF-1:0]    inj_valid,
  output logic [NLEAF-1:0]    inj_ready,
  input  logic [NLEAF*IW-1:0] inj_data,
  output logic [NLEAF-1:0]    ej_valid,
  input  logic [NLEAF-1:0]    ej_ready,
  output logic [NLEAF*EW-1:0] ej_data
);
  localparam int PKW     = $clog2(LEVELS+1) + EW;
  localparam int NODES   = 2 * NLEAF - 1;
  localparam int ROOT_ID = NODES - 1;

  function automatic int lvl_base(input int lv);
    return 2 * NLEAF - (1 << (LEVELS - lv + 1));
  endfunction

  logic           up_v [NODES];
  logic           up_r [NODES];
  logic [PKW-1:0] up_d [NODES];
  logic           dn_v [NODES];
  logic           dn_r [NODES];
  logic [PKW-1:0] dn_d [NODES];

  for (genvar g = 0; g < NLEAF; g++) begin : g_leaf
    ht_leaf #(.LEVELS(LEVELS), .PAY_W(PAY_W), .ID(g)) u_leaf (
      .clk(clk), .rst_n(rst_n),
      .inj_valid(inj_valid[g]), .inj_ready(inj_ready[g]), .inj_data(inj_data[g*IW +: IW]),
      .up_valid(up_v[g]), .up_ready(up_r[g]), .up_data(up_d[g]),
      .dn_valid(dn_v[g]), .dn_ready(dn_r[g]), .dn_data(dn_d[g]),
      .ej_valid(ej_valid[g]), .ej_ready(ej_ready[g]), .ej_data(ej_data[g*EW +: EW])
    );
  end

  for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
    for (genvar j = 0; j < (NLEAF >> lv); j++) begin : g_sw
      localparam int S  = lvl_base(lv) + j;
      localparam int C0 = lvl_base(lv - 1) + 2 * j;
      ht_switch #(.LEVELS(LEVELS), .PAY_W(PAY_W), .LEVEL(lv), .ROOT(lv == LEVELS)) u_sw (
        .clk(clk), .rst_n(rst_n),
        .cl_valid(up_v[C0]),   .cl_ready(up_r[C0]),   .cl_data(up_d[C0]),
        .cr_valid(up_v[C0+1]), .cr_ready(up_r[C0+1]), .cr_data(up_d[C0+1]),
        .pa_valid(dn_v[S]),    .pa_ready(dn_r[S]),    .pa_data(dn_d[S]),
        .up_valid(up_v[S]),    .up_ready(up_r[S]),    .up_data(up_d[S]),
        .lf_valid(dn_v[C0]),   .lf_ready(dn_r[C0]),   .lf_data(dn_d[C0]),
        .rt_valid(dn_v[C0+1]), .rt_ready(dn_r[C0+1]), .rt_data(dn_d[C0+1])
      );
    end
  end

  assign up_r[ROOT_ID] = 1'b0;
  assign dn_v[ROOT_ID] = 1'b0;
  assign dn_d[ROOT_ID] = '0;

  // R7
  root_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_v[ROOT_ID] && dn_r[ROOT_ID]);
endmodule

// File: tb/ht_tree_fabric_test.sv
`timescale 1ns/1ps
module ht_tree_fabric_test;
  localparam int LV = 3;
  localparam int PW = 8;
  localparam int NL = 1 << LV;
  localparam int HW = $clog2(2 * LV + 1);
  localparam int IW = LV + PW;
  localparam int EW = HW + 2 * LV + PW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [NL-1:0]    inj_valid = '0;
  logic [NL-1:0]    inj_ready;
  logic [NL*IW-1:0] inj_data = '0;
  logic [NL-1:0]    ej_valid;
  logic [NL-1:0]    ej_ready = '0;
  logic [NL*EW-1:0] ej_data;

  ht_tree_fabric #(.LEVELS(LV), .PAY_W(PW)) uut (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_data(ej_data)
  );

  int checks = 0, fails = 0;
  int n_sent = 0, n_got = 0;
  int bp_pct = 0;
  bit flood_on = 0;
  logic [IW-1:0] txq [NL][$];
  bit fire_pend [NL];
  bit stall_chk [NL];
  logic [EW-1:0] stall_data [NL];
  int exp_src [256];
  int exp_dst [256];
  bit seen [256];
  int flood_src [$];

  function automatic int top_bit(input int v);
    int r;
    r = -1;
    for (int b = 0; b < 16; b++) if (v[b]) r = b;
    return r;
  endfunction

  function automatic int exp_hops(input int a, input int b);
    if (a == b) return 0;
    return 2 * (top_bit(a ^ b) + 1);
  endfunction

  task automatic send(input int s, input int d);
    exp_src[n_sent] = s;
    exp_dst[n_sent] = d;
    txq[s].push_back({LV'(d), PW'(n_sent)});
    n_sent++;
  endtask

  task automatic check_pkt(input int l, input logic [EW-1:0] w);
    int id, src, dst, hops, eh;
    id   = int'(w[PW-1:0]);
    dst  = int'(w[PW +: LV]);
    src  = int'(w[PW+LV +: LV]);
    hops = int'(w[PW+2*LV +: HW]);
    checks++;
    if (dst != l || exp_dst[id] != l) begin
      fails++;
      $display("FAIL R1 leaf %0d id %0d dst=%0d expected %0d", l, id, dst, exp_dst[id]);
    end
    checks++;
    if (src != exp_src[id]) begin
      fails++;
      $display("FAIL R1 id %0d src=%0d expected %0d", id, src, exp_src[id]);
    end
    eh = exp_hops(exp_src[id], exp_dst[id]);
    checks++;
    if (hops != eh) begin
      fails++;
      if (exp_src[id] == exp_dst[id])
        $display("FAIL R3 id %0d hops=%0d expected %0d", id, hops, eh);
      else
        $display("FAIL R2/R7 id %0d hops=%0d expected %0d", id, hops, eh);
    end
    checks++;
    if (id >= n_sent || seen[id]) begin
      fails++;
      $display("FAIL R4 id %0d duplicate or unknown, seen=%0d expected 0", id, seen[id]);
    end
    seen[id] = 1'b1;
    n_got++;
    if (flood_on && l == 2) flood_src.push_back(src);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < NL; l++) begin
        if (fire_pend[l]) begin
          void'(txq[l].pop_front());
          checks++;
          if (inj_ready[l] !== 1'b0) begin
            fails++;
            $display("FAIL R6 leaf %0d inj_ready=%b expected 0", l, inj_ready[l]);
          end
          fire_pend[l] = 1'b0;
        end
        if (txq[l].size() > 0) begin
          inj_valid[l] = 1'b1;
          inj_data[l*IW +: IW] = txq[l][0];
        end else begin
          inj_valid[l] = 1'b0;
        end
        fire_pend[l] = inj_valid[l] && inj_ready[l];
        ej_ready[l] = ($urandom_range(99) >= bp_pct);
      end
      #1;
      for (int l = 0; l < NL; l++) begin
        if (stall_chk[l]) begin
          checks++;
          if (!ej_valid[l] || ej_data[l*EW +: EW] !== stall_data[l]) begin
            fails++;
            $display("FAIL R5 leaf %0d valid=%b data=%h expected 1 %h",
                     l, ej_valid[l], ej_data[l*EW +: EW], stall_data[l]);
          end
          stall_chk[l] = 1'b0;
        end
        if (ej_valid[l] && ej_ready[l]) check_pkt(l, ej_data[l*EW +: EW]);
        else if (ej_valid[l]) begin
          stall_chk[l]  = 1'b1;
          stall_data[l] = ej_data[l*EW +: EW];
        end
      end
    end
  end

  task automatic drain();
    while (n_got < n_sent) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: received %0d expected %0d", n_got, n_sent);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int run, best, missing, c0, c1;
    void'($urandom(32'd7321));
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (inj_ready !== {NL{1'b1}} || ej_valid !== '0) begin
      fails++;
      $display("FAIL R6 reset inj_ready=%b ej_valid=%b expected %b 0", inj_ready, ej_valid, {NL{1'b1}});
    end
    rst_n = 1'b1;

    // R1 R2 R3: every source/destination pair, no back-pressure
    for (int s = 0; s < NL; s++)
      for (int d = 0; d < NL; d++) send(s, d);
    drain();

    // R4 R5: directed extremes plus random traffic under back-pressure
    bp_pct = 40;
    send(0, NL - 1);
    send(NL - 1, 0);
    send(NL/2 - 1, NL/2);
    for (int k = 0; k < 130; k++) send($urandom_range(NL - 1), $urandom_range(NL - 1));
    drain();

    // R8: two leaves flood one destination
    bp_pct = 0;
    flood_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      send(0, 2);
      send(1, 2);
    end
    drain();
    flood_on = 1'b0;

    run = 0; best = 0; c0 = 0; c1 = 0;
    for (int k = 0; k < flood_src.size(); k++) begin
      if (flood_src[k] == 0) c0++; else c1++;
      if (k > 0 && flood_src[k] == flood_src[k-1]) run++; else run = 1;
      if (run > best) best = run;
    end
    checks++;
    if (best > 2) begin
      fails++;
      $display("FAIL R8 longest same-source run=%0d expected <= 2", best);
    end
    checks++;
    if (c0 != 12 || c1 != 12) begin
      fails++;
      $display("FAIL R8 arrivals %0d/%0d expected 12/12", c0, c1);
    end

    missing = 0;
    for (int k = 0; k < n_sent; k++) if (!seen[k]) missing++;
    checks++;
    if (missing != 0) begin
      fails++;
      $display("FAIL R4 missing=%0d expected 0", missing);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule